// File: doc/BRIEF.md
# Programmable Product-Term AND Plane

This block is the configurable AND plane of a wide logic block in a programmable-logic fabric. Each routed input is turned into two array lines, one carrying the signal and one carrying its inverse. A configuration store decides which lines feed each product term. Every term is the logical AND of the lines enabled for it. A term with no lines enabled drives logic 0.

The configuration is one long shift register. It takes one bit per clock while a load-enable input is high. When load-enable is low it keeps its contents. Reset clears it to all-disconnected.

The product terms come out in two groups. The first group holds the logic terms, grouped into fixed clusters of five, one cluster per macrocell. The second group holds three shared control terms: a common clock, a common reset and a common output enable. Four fixed positions in each cluster are also brought out on their own as the per-macrocell control terms: output enable, clock, preset and reset. The downstream OR stage and macrocells take these outputs directly. Once the configuration is loaded, every output is purely combinational in the inputs.

Top module: `pta_and_plane`

## Requirements
- R1: An active-low reset clears every configuration bit. While the store is clear, every product-term output is 0 for any input value.
- R2: While `cfg_load_en` is high, each rising clock edge shifts `cfg_din` into bit 0 of the store and moves every other bit up by one index. Bit `t*136 + l` enables line `l` of term `t`. Line `2i` is input `i` true and line `2i+1` is input `i` inverted. A bit shifted in first and then followed by k more bits ends at index k.
- R3: While `cfg_load_en` is low, the store keeps its contents whatever `cfg_din` does, so the outputs for a given input do not change.
- R4: Each product term is the AND of all the lines its configuration enables. Enabling both polarities of one input gives a constant 0.
- R5: A product term with no enabled lines outputs 0.
- R6: Terms 0 to 159 appear on `logic_pt` at their own index. Terms 160, 161 and 162 appear on `shared_pt` bits 0 (shared clock), 1 (shared reset) and 2 (shared output enable).
- R7: Cluster c holds terms 5c to 5c+4. `mc_oe[c]` carries term 5c, `mc_clk[c]` carries term 5c+2, `mc_preset[c]` carries term 5c+3 and `mc_reset[c]` carries term 5c+4.
- R8: With the store held, the outputs follow a change on `in_sig` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_load_en | input | 1 | Shift enable for the configuration store |
| cfg_din | input | 1 | Serial configuration data |
| in_sig | input | 68 | Routed input signals |
| logic_pt | output | 160 | Logic product terms, cluster by cluster |
| shared_pt | output | 3 | Shared clock, reset and output-enable terms |
| mc_oe | output | 32 | Per-cluster output-enable term |
| mc_clk | output | 32 | Per-cluster clock term |
| mc_preset | output | 32 | Per-cluster preset term |
| mc_reset | output | 32 | Per-cluster reset term |

## Verification
The hardest part to confirm from the ports is where a serially loaded bit ends up. A wrong index or a wrong polarity only shows when the right input pattern hits the one term that bit controls. The stimulus therefore loads full configurations in which every term follows a closed-form rule: one true literal and one inverted literal per term, with deliberately empty and deliberately contradictory terms among them. It then walks a table of input vectors and compares each term with the value predicted from that rule. A separate load shifts in a single 1 followed by a counted run of zeros, so that exactly one line of the shared output-enable term is enabled. This places the bit at a known index and shows the shift order directly at the outputs.

// File: rtl/pta_pkg.sv
package pta_pkg;
  // Position of each per-macrocell control term inside a cluster.
  localparam int unsigned ROLE_OE  = 0;
  localparam int unsigned ROLE_CLK = 2;
  localparam int unsigned ROLE_PRE = 3;
  localparam int unsigned ROLE_RST = 4;

  // Order of the shared control terms after the logic terms.
  typedef enum logic [1:0] {
    SH_CLK = 2'd0,
    SH_RST = 2'd1,
    SH_OE  = 2'd2
  } shared_role_e;

  localparam int unsigned N_SHARED = 3;
endpackage

// File: rtl/pta_line_gen.sv
module pta_line_gen #(
  parameter int unsigned N_IN = 68,
  localparam int unsigned N_LINES = 2 * N_IN
) (
  input  logic [N_IN-1:0]    in_sig,
  output logic [N_LINES-1:0] lines
);
  // Even line: true input. Odd line: inverted input.
  for (genvar i = 0; i < N_IN; i++) begin : g_pair
    assign lines[2*i]   = in_sig[i];
    assign lines[2*i+1] = ~in_sig[i];
  end
endmodule

// File: rtl/pta_cfg_chain.sv
module pta_cfg_chain #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[W-2:0], din};
    end
  end
endmodule

// File: rtl/pta_term.sv
module pta_term #(
  parameter int unsigned N_LINES = 136
) (
  input  logic [N_LINES-1:0] lines,
  input  logic [N_LINES-1:0] en,
  output logic               pt
);
  // AND of enabled lines. Disabled lines are forced to 1; no enables gives 0.
  function automatic logic wired_and(input logic [N_LINES-1:0] l,
                                     input logic [N_LINES-1:0] e);
    return (|e) & (&(l | ~e));
  endfunction

  assign pt = wired_and(lines, en);
endmodule

// File: rtl/pta_and_plane.sv
module pta_and_plane #(
  parameter int unsigned N_IN       = 68,
  parameter int unsigned N_CLUSTERS = 32,
  parameter int unsigned CLUSTER_SZ = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_load_en,
  input  logic                                cfg_din,
  input  logic [N_IN-1:0]                     in_sig,
  output logic [N_CLUSTERS*CLUSTER_SZ-1:0]    logic_pt,
  output logic [pta_pkg::N_SHARED-1:0]        shared_pt,
  output logic [N_CLUSTERS-1:0]               mc_oe,
  output logic [N_CLUSTERS-1:0]               mc_clk,
  output logic [N_CLUSTERS-1:0]               mc_preset,
  output logic [N_CLUSTERS-1:0]               mc_reset
);
  import pta_pkg::*;

  localparam int unsigned N_LINES = 2 * N_IN;
  localparam int unsigned N_LOGIC = N_CLUSTERS * CLUSTER_SZ;
  localparam int unsigned N_TERMS = N_LOGIC + N_SHARED;
  localparam int unsigned CFG_W   = N_TERMS * N_LINES;

  logic [N_LINES-1:0] lines;
  logic [CFG_W-1:0]   cfg_q;
  logic [N_TERMS-1:0] all_pt;
  logic [N_TERMS-1:0] term_empty;

  pta_line_gen #(.N_IN(N_IN)) u_lines (
    .in_sig (in_sig),
    .lines  (lines)
  );

  pta_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_load_en),
    .din      (cfg_din),
    .q        (cfg_q)
  );

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    pta_term #(.N_LINES(N_LINES)) u_term (
      .lines (lines),
      .en    (cfg_q[t*N_LINES +: N_LINES]),
      .pt    (all_pt[t])
    );
    // Marks a term with no lines enabled; used by the checker.
    assign term_empty[t] = (cfg_q[t*N_LINES +: N_LINES] == '0);
  end

  assign logic_pt = all_pt[N_LOGIC-1:0];

  for (genvar s = 0; s < N_SHARED; s++) begin : g_shared
    assign shared_pt[s] = all_pt[N_LOGIC + s];
  end

  for (genvar c = 0; c < N_CLUSTERS; c++) begin : g_cluster
    assign mc_oe[c]     = logic_pt[c*CLUSTER_SZ + ROLE_OE];
    assign mc_clk[c]    = logic_pt[c*CLUSTER_SZ + ROLE_CLK];
    assign mc_preset[c] = logic_pt[c*CLUSTER_SZ + ROLE_PRE];
    assign mc_reset[c]  = logic_pt[c*CLUSTER_SZ + ROLE_RST];
  end
endmodule

// File: rtl/pta_and_plane_chk.sv
module pta_and_plane_chk #(
  parameter int unsigned CFG_W   = 64,
  parameter int unsigned N_TERMS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_load_en,
  input logic               cfg_din,
  input logic [CFG_W-1:0]   cfg_q,
  input logic [N_TERMS-1:0] term_empty,
  input logic [N_TERMS-1:0] all_pt
);
  // R1: after a cycle in reset, at most bit 0 can have been loaded since.
  a_r1_reset_clears: assert property (@(posedge clk)
    (!rst_n) |=> (cfg_q[CFG_W-1:1] == '0));

  // R2: the serial bit lands at index 0 on the next edge.
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_en |=> (cfg_q[0] == $past(cfg_din)));

  // R3: no load means the store stays the same.
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load_en) |=> $stable(cfg_q));

  // R5: an unconnected term never asserts.
  a_r5_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((term_empty & all_pt) == '0));
endmodule

bind pta_and_plane pta_and_plane_chk #(
  .CFG_W   (CFG_W),
  .N_TERMS (N_TERMS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_load_en (cfg_load_en),
  .cfg_din     (cfg_din),
  .cfg_q       (cfg_q),
  .term_empty  (term_empty),
  .all_pt      (all_pt)
);

// File: tb/pta_and_plane_tb.sv
module pta_and_plane_tb;
  localparam int NI = 68;
  localparam int NC = 32;
  localparam int NL = 160;
  localparam int NT = 163;
  localparam int LW = 136;
  localparam int CW = NT * LW;
  localparam int SINGLE_IDX = 162 * LW + 10;  // term 162, input 5 true

  localparam logic [NI-1:0] VEC [8] = '{
    68'h0_0000_0000_0000_0000,
    68'hF_FFFF_FFFF_FFFF_FFFF,
    68'h5_5555_5555_5555_5555,
    68'hA_AAAA_AAAA_AAAA_AAAA,
    68'h0_0000_0000_0000_0401,
    68'h0_0000_0000_0010_0400,
    68'h7_FFFF_FFFF_FFFF_FFFF,
    68'h1_2345_6789_ABCD_EF01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load_en = 1'b0;
  logic cfg_din = 1'b0;
  logic [NI-1:0] in_sig = '0;
  logic [NL-1:0] logic_pt;
  logic [2:0] shared_pt;
  logic [NC-1:0] mc_oe, mc_clk, mc_preset, mc_reset;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pta_and_plane u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load_en(cfg_load_en), .cfg_din(cfg_din),
    .in_sig(in_sig), .logic_pt(logic_pt), .shared_pt(shared_pt),
    .mc_oe(mc_oe), .mc_clk(mc_clk), .mc_preset(mc_preset), .mc_reset(mc_reset)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Pattern 0: term t = in[t%68] & ~in[(7t+3)%68]; every 32nd term empty.
  // Pattern 1: logic terms use both polarities of one input.
  // Pattern 2: a single line (term 162, input 5 true).
  function automatic bit en_bit(input int pat, input int idx);
    int t, l, inp;
    bit inv;
    t = idx / LW; l = idx % LW; inp = l / 2; inv = bit'(l % 2);
    case (pat)
      0: begin
        if (t < NL) begin
          if (t % 32 == 31) return 1'b0;
          return (!inv && inp == t % NI) || (inv && inp == (t*7+3) % NI);
        end
        if (t == 160) return !inv && inp == 0;
        if (t == 161) return inv && inp == 67;
        return !inv;
      end
      1: begin
        if (t < NL) return inp == t % NI;
        if (t == 160) return 1'b0;
        if (t == 161) return inv;
        return !inv && (inp == 10 || inp == 20);
      end
      default: return idx == SINGLE_IDX;
    endcase
  endfunction

  function automatic bit exp_term(input int pat, input int t, input logic [NI-1:0] v);
    case (pat)
      0: begin
        if (t < NL) return (t % 32 == 31) ? 1'b0 : (v[t % NI] & ~v[(t*7+3) % NI]);
        if (t == 160) return v[0];
        if (t == 161) return ~v[67];
        return &v;
      end
      1: begin
        if (t < 161) return 1'b0;
        if (t == 161) return v == '0;
        return v[10] & v[20];
      end
      default: return (t == 162) ? v[5] : 1'b0;
    endcase
  endfunction

  task automatic load_pattern(input int pat);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_load_en = 1'b1;
      cfg_din = en_bit(pat, i);
    end
    @(negedge clk);
    cfg_load_en = 1'b0;
    cfg_din = 1'b0;
  endtask

  task automatic check_vec(input int pat, input logic [NI-1:0] v, input string tag);
    logic [NL-1:0] el;
    logic [2:0] es;
    logic [NC-1:0] eo, ec, ep, er;
    for (int t = 0; t < NL; t++) el[t] = exp_term(pat, t, v);
    for (int s = 0; s < 3; s++) es[s] = exp_term(pat, NL + s, v);
    for (int c = 0; c < NC; c++) begin
      eo[c] = el[5*c]; ec[c] = el[5*c+2]; ep[c] = el[5*c+3]; er[c] = el[5*c+4];
    end
    in_sig = v;
    #1;  // no clock edge in between: R8
    chk(logic_pt == el, {tag, " R4/R5/R6/R8 logic terms"}, logic_pt, el);
    chk(shared_pt == es, {tag, " R6 shared terms"}, NL'(shared_pt), NL'(es));
    chk({mc_oe, mc_clk, mc_preset, mc_reset} == {eo, ec, ep, er},
        {tag, " R7 cluster control terms"},
        NL'({mc_oe, mc_clk, mc_preset, mc_reset}), NL'({eo, ec, ep, er}));
  endtask

  task automatic run_table(input int pat, input string tag);
    for (int k = 0; k < 8; k++) check_vec(pat, VEC[k], tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: cleared store -> all outputs 0
    check_vec(2, '0, "reset R1");
    in_sig = '1; #1;
    chk({logic_pt, shared_pt} == '0, "R1 reset state, inputs high",
        NL'(logic_pt), '0);
    rst_n = 1'b1;

    load_pattern(0);
    run_table(0, "patA");

    load_pattern(1);
    run_table(1, "patB");

    // R3: toggle serial data with load low
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cfg_din = bit'(i % 3 == 0);
    end
    cfg_din = 1'b0;
    run_table(1, "hold R3");

    // R1: reset mid-run clears a loaded store
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    in_sig = '1; #1;
    chk({logic_pt, shared_pt} == '0, "R1 reset after load", NL'(logic_pt), '0);
    chk(shared_pt == 3'b000, "R1 shared after reset", NL'(shared_pt), '0);
    rst_n = 1'b1;

    // R2: one 1 followed by SINGLE_IDX zeros lands at index SINGLE_IDX
    @(negedge clk);
    cfg_load_en = 1'b1; cfg_din = 1'b1;
    for (int i = 0; i < SINGLE_IDX; i++) begin
      @(negedge clk);
      cfg_din = 1'b0;
    end
    @(negedge clk);
    cfg_load_en = 1'b0;
    run_table(2, "shift R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule